// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block is a purely combinational decoder for the 32-bit floating-point instruction words of a RISC load/store machine. It examines the six-bit primary opcode and, where the primary opcode requires it, an extended opcode. From these it produces four kinds of output:

- an operation code;
- a four-bit operand-form class;
- a precision flag;
- the register and immediate fields that the chosen form actually uses.

The decoder sits in front of the floating-point execution, load/store and status units. Those units perform all arithmetic, address generation, memory access and status-register updates.

The record flag (instruction bit 0) is passed through on every legal instruction. A later stage uses it to copy the top four status bits into condition field 1. An instruction that is not recognised raises the illegal flag and drives every other output to zero.

Top module: `fp_insn_decoder`

## Requirements
- R1: Primary opcodes 48..55 decode as memory forms. Bit 2 of the primary opcode selects store, bit 1 selects double (this is the precision flag), and bit 0 selects update. The form is 4 (plain) or 5 (update). The target field (bits 25:21), base field (bits 20:16) and 16-bit displacement (bits 15:0) are routed out.
- R2: Primary opcode 31 with extended opcode (bits 10:1) 535, 567, 599, 631, 663, 695, 727 or 759 decodes as an indexed load/store. Within that range, extended-opcode bit 7 selects store, bit 6 selects double and bit 5 selects update. The form is 8 (plain) or 9 (update), and T, A and B (bits 15:11) are routed out.
- R3: Primary opcode 31 with extended opcode 983 decodes as store-as-integer-word, with form 8 and the precision flag 0.
- R4: Primary opcode 59 decodes the five-bit field (bits 5:1) as a single-precision operation:
  - 18 divide, 20 subtract, 21 add and 25 multiply;
  - 22 square root, 24 reciprocal estimate and 26 reciprocal square-root estimate;
  - 28 multiply-subtract, 29 multiply-add, 30 negated multiply-subtract and 31 negated multiply-add.

  Any other value, including 23, is illegal.
- R5: Primary opcode 63 with bit 5 set decodes the same five-bit table with the precision flag 1, and additionally accepts 23 as select. Any other value is illegal.
- R6: Primary opcode 63 with bit 5 clear decodes the ten-bit extended opcode as follows:
  - 0 unordered compare and 32 ordered compare;
  - 12 round to single, 14 convert to integer word and 15 convert to integer word toward zero;
  - 40 negate, 72 move, 136 negative absolute and 264 absolute;
  - 38 set status bit and 70 clear status bit;
  - 64 status field to condition field and 134 status field immediate;
  - 583 read status and 711 write status fields.

  Any other value is illegal. Every opcode-63 instruction reports the precision flag 1.
- R7: Form codes and routing for arithmetic are as follows. Fields a form does not use read zero.
  - Two-source (form 1) routes T, A and B.
  - Multiply (form 2) routes T, A and C (bits 10:6).
  - Fused and select (form 3) route T, A, B and C.
  - Unary (form 7) routes T and B.
  - Read status (form 6) routes only T.
- R8: Compares (form 10) route the condition field (bits 25:23), A and B. Status-to-condition (form 11) routes the condition field and a source field (bits 20:18).
- R9: The remaining status instructions route these fields:
  - Status-field-immediate (form 13) routes the field number (bits 25:23) and a four-bit immediate (bits 15:12).
  - Write-fields (form 14) routes an eight-bit mask (bits 24:17) and B.
  - Set and clear status bit (form 12) route a bit number (bits 25:21).
- R10: The record output equals instruction bit 0 on every legal instruction.
- R11: An unknown primary opcode, or an unmatched extended opcode under 31, 59 or 63, raises the illegal flag. In that case the operation code is the package's empty value, the form is 0, and the precision, record and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| op | output | 6 | Decoded operation (package enumeration) |
| form | output | 4 | Operand-form class |
| isDouble | output | 1 | Double-precision flag |
| record | output | 1 | Record flag |
| illegal | output | 1 | Unrecognised instruction |
| regT | output | 5 | Target register field |
| regA | output | 5 | A register field |
| regB | output | 5 | B register field |
| regC | output | 5 | C register field |
| crField | output | 3 | Destination condition/status field |
| crSrc | output | 3 | Source status field |
| imm4 | output | 4 | Status immediate |
| fieldMask | output | 8 | Status field mask |
| bitNum | output | 5 | Status bit number |
| disp | output | 16 | Memory displacement |

## Verification
The bench builds the block with its package defaults: a 32-bit word, five-bit register fields and the fixed field positions. With these defaults it can reach every legal entry of all four opcode tables. It can also reach the near misses next to each table: 23 under opcode 59, an odd five-bit value under opcode 63, and an unmatched ten-bit value under 31 and 63. Each form is driven with distinct field values, so any misrouted or unmasked field shows up at the ports.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
  localparam int INSN_W  = 32;
  localparam int PRIM_W  = 6;
  localparam int XO_W    = 10;
  localparam int XO5_W   = 5;
  localparam int REG_W   = 5;
  localparam int CRF_W   = 3;
  localparam int IMM_W   = 4;
  localparam int MASK_W  = 8;
  localparam int DISP_W  = 16;
  localparam int OP_W    = 6;
  localparam int FORM_W  = 4;
  localparam int LOW_W   = INSN_W - PRIM_W;   // bits carrying fields
  localparam int T_LSB   = 21;
  localparam int A_LSB   = 16;
  localparam int B_LSB   = 11;
  localparam int C_LSB   = 6;
  localparam int CRF_LSB = 23;
  localparam int CRS_LSB = 18;
  localparam int IMM_LSB = 12;
  localparam int MSK_LSB = 17;

  typedef enum logic [OP_W-1:0] {
    OP_NONE, OP_LD_S, OP_LD_D, OP_ST_S, OP_ST_D, OP_ST_IW,
    OP_DIV, OP_SUB, OP_ADD, OP_SQRT, OP_RECIP_EST, OP_MUL, OP_RSQRT_EST,
    OP_MSUB, OP_MADD, OP_NMSUB, OP_NMADD, OP_SEL,
    OP_CMP_U, OP_CMP_O, OP_RND_SGL, OP_CVT_W, OP_CVT_WZ,
    OP_NEG, OP_ABS, OP_NABS, OP_MOVE,
    OP_STAT_RD, OP_STAT_WRF, OP_STAT_IMM, OP_STAT_SET, OP_STAT_CLR, OP_STAT_TOCR
  } fpOp_e;

  typedef enum logic [FORM_W-1:0] {
    FORM_NONE = 4'd0, FORM_AB = 4'd1, FORM_AC = 4'd2, FORM_ABC = 4'd3,
    FORM_D = 4'd4, FORM_DU = 4'd5, FORM_X = 4'd6, FORM_XB = 4'd7,
    FORM_XE = 4'd8, FORM_XEU = 4'd9, FORM_CMP = 4'd10, FORM_CRL = 4'd11,
    FORM_BIT = 4'd12, FORM_IMM = 4'd13, FORM_MASK = 4'd14
  } fpForm_e;

  typedef struct packed {
    logic selT;
    logic selA;
    logic selB;
    logic selC;
    logic selDisp;
    logic selCrf;
    logic selCrs;
    logic selImm;
    logic selMask;
    logic selBit;
  } fieldStrobe_t;
endpackage

// File: rtl/fpdec_ctrl.sv
module fpdec_ctrl
  import fpdec_pkg::*;
(
  input  logic [PRIM_W-1:0] prim,
  input  logic [XO_W-1:0]   xo,
  input  logic              rc,
  output fpOp_e             op,
  output fpForm_e           form,
  output logic              isDouble,
  output logic              record,
  output logic              illegal,
  output fieldStrobe_t      stb
);
  localparam logic [XO5_W-1:0] XO5_SEL = 5'd23;

  logic [XO5_W-1:0] xo5;
  assign xo5 = xo[XO5_W-1:0];

  // Short-form arithmetic table shared by single and double precision.
  function automatic fpOp_e arithOf(input logic [XO5_W-1:0] v, input logic allowSel);
    case (v)
      5'd18:   arithOf = OP_DIV;
      5'd20:   arithOf = OP_SUB;
      5'd21:   arithOf = OP_ADD;
      5'd22:   arithOf = OP_SQRT;
      5'd24:   arithOf = OP_RECIP_EST;
      5'd25:   arithOf = OP_MUL;
      5'd26:   arithOf = OP_RSQRT_EST;
      5'd28:   arithOf = OP_MSUB;
      5'd29:   arithOf = OP_MADD;
      5'd30:   arithOf = OP_NMSUB;
      5'd31:   arithOf = OP_NMADD;
      XO5_SEL: arithOf = allowSel ? OP_SEL : OP_NONE;
      default: arithOf = OP_NONE;
    endcase
  endfunction

  function automatic fpForm_e arithForm(input fpOp_e o);
    case (o)
      OP_DIV, OP_SUB, OP_ADD:                  arithForm = FORM_AB;
      OP_MUL:                                  arithForm = FORM_AC;
      OP_MSUB, OP_MADD, OP_NMSUB, OP_NMADD,
      OP_SEL:                                  arithForm = FORM_ABC;
      OP_SQRT, OP_RECIP_EST, OP_RSQRT_EST:     arithForm = FORM_XB;
      default:                                 arithForm = FORM_NONE;
    endcase
  endfunction

  fpOp_e   rawOp;
  fpForm_e rawForm;
  logic    rawDbl;

  always_comb begin
    rawOp   = OP_NONE;
    rawForm = FORM_NONE;
    rawDbl  = 1'b0;
    case (prim)
      6'd48, 6'd49, 6'd50, 6'd51, 6'd52, 6'd53, 6'd54, 6'd55: begin
        rawDbl  = prim[1];
        rawOp   = prim[2] ? (prim[1] ? OP_ST_D : OP_ST_S)
                          : (prim[1] ? OP_LD_D : OP_LD_S);
        rawForm = prim[0] ? FORM_DU : FORM_D;
      end
      6'd31: begin
        case (xo) inside
          10'd983: begin
            rawOp   = OP_ST_IW;
            rawForm = FORM_XE;
          end
          10'b10???10111: begin
            rawDbl  = xo[6];
            rawOp   = xo[7] ? (xo[6] ? OP_ST_D : OP_ST_S)
                            : (xo[6] ? OP_LD_D : OP_LD_S);
            rawForm = xo[5] ? FORM_XEU : FORM_XE;
          end
          default: ;
        endcase
      end
      6'd59: begin
        rawOp   = arithOf(xo5, 1'b0);
        rawForm = arithForm(rawOp);
      end
      6'd63: begin
        rawDbl = 1'b1;
        if (xo[4]) begin
          rawOp   = arithOf(xo5, 1'b1);
          rawForm = arithForm(rawOp);
        end else begin
          case (xo)
            10'd0:   begin rawOp = OP_CMP_U;     rawForm = FORM_CMP;  end
            10'd32:  begin rawOp = OP_CMP_O;     rawForm = FORM_CMP;  end
            10'd12:  begin rawOp = OP_RND_SGL;   rawForm = FORM_XB;   end
            10'd14:  begin rawOp = OP_CVT_W;     rawForm = FORM_XB;   end
            10'd15:  begin rawOp = OP_CVT_WZ;    rawForm = FORM_XB;   end
            10'd40:  begin rawOp = OP_NEG;       rawForm = FORM_XB;   end
            10'd72:  begin rawOp = OP_MOVE;      rawForm = FORM_XB;   end
            10'd136: begin rawOp = OP_NABS;      rawForm = FORM_XB;   end
            10'd264: begin rawOp = OP_ABS;       rawForm = FORM_XB;   end
            10'd38:  begin rawOp = OP_STAT_SET;  rawForm = FORM_BIT;  end
            10'd70:  begin rawOp = OP_STAT_CLR;  rawForm = FORM_BIT;  end
            10'd64:  begin rawOp = OP_STAT_TOCR; rawForm = FORM_CRL;  end
            10'd134: begin rawOp = OP_STAT_IMM;  rawForm = FORM_IMM;  end
            10'd583: begin rawOp = OP_STAT_RD;   rawForm = FORM_X;    end
            10'd711: begin rawOp = OP_STAT_WRF;  rawForm = FORM_MASK; end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    illegal  = (rawOp == OP_NONE);
    op       = rawOp;
    form     = illegal ? FORM_NONE : rawForm;
    isDouble = rawDbl & ~illegal;
    record   = rc & ~illegal;
    stb      = '0;
    case (form)
      FORM_D, FORM_DU:           begin stb.selT = 1'b1; stb.selA = 1'b1; stb.selDisp = 1'b1; end
      FORM_XE, FORM_XEU, FORM_AB: begin stb.selT = 1'b1; stb.selA = 1'b1; stb.selB = 1'b1; end
      FORM_AC:                   begin stb.selT = 1'b1; stb.selA = 1'b1; stb.selC = 1'b1; end
      FORM_ABC: begin
        stb.selT = 1'b1; stb.selA = 1'b1; stb.selB = 1'b1; stb.selC = 1'b1;
      end
      FORM_XB:                   begin stb.selT = 1'b1; stb.selB = 1'b1; end
      FORM_X:                    stb.selT = 1'b1;
      FORM_CMP:                  begin stb.selCrf = 1'b1; stb.selA = 1'b1; stb.selB = 1'b1; end
      FORM_CRL:                  begin stb.selCrf = 1'b1; stb.selCrs = 1'b1; end
      FORM_BIT:                  stb.selBit = 1'b1;
      FORM_IMM:                  begin stb.selCrf = 1'b1; stb.selImm = 1'b1; end
      FORM_MASK:                 begin stb.selMask = 1'b1; stb.selB = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    // R11
    illegal_quiet_chk: assert (!illegal || (form == FORM_NONE && !isDouble && !record && stb == '0))
      else $error("illegal word left outputs active");
    // R11
    prim_known_chk: assert (illegal || prim inside {6'd31, 6'd59, 6'd63, [6'd48:6'd55]})
      else $error("unknown primary opcode accepted");
    // R1
    mem_form_chk: assert (!(op inside {OP_LD_S, OP_LD_D, OP_ST_S, OP_ST_D, OP_ST_IW}) ||
                          (form inside {FORM_D, FORM_DU, FORM_XE, FORM_XEU}))
      else $error("memory op with non-memory form");
    // R9
    status_excl_chk: assert ($onehot0({stb.selBit, stb.selImm, stb.selMask, stb.selCrs}))
      else $error("status field strobes overlap");
  end
endmodule

// File: rtl/fpdec_fields.sv
module fpdec_fields
  import fpdec_pkg::*;
(
  input  logic [LOW_W-1:0]  bits,
  input  fieldStrobe_t      stb,
  output logic [REG_W-1:0]  regT,
  output logic [REG_W-1:0]  regA,
  output logic [REG_W-1:0]  regB,
  output logic [REG_W-1:0]  regC,
  output logic [CRF_W-1:0]  crField,
  output logic [CRF_W-1:0]  crSrc,
  output logic [IMM_W-1:0]  imm4,
  output logic [MASK_W-1:0] fieldMask,
  output logic [REG_W-1:0]  bitNum,
  output logic [DISP_W-1:0] disp
);
  assign regT      = stb.selT    ? bits[T_LSB   +: REG_W]  : '0;
  assign regA      = stb.selA    ? bits[A_LSB   +: REG_W]  : '0;
  assign regB      = stb.selB    ? bits[B_LSB   +: REG_W]  : '0;
  assign regC      = stb.selC    ? bits[C_LSB   +: REG_W]  : '0;
  assign crField   = stb.selCrf  ? bits[CRF_LSB +: CRF_W]  : '0;
  assign crSrc     = stb.selCrs  ? bits[CRS_LSB +: CRF_W]  : '0;
  assign imm4      = stb.selImm  ? bits[IMM_LSB +: IMM_W]  : '0;
  assign fieldMask = stb.selMask ? bits[MSK_LSB +: MASK_W] : '0;
  assign bitNum    = stb.selBit  ? bits[T_LSB   +: REG_W]  : '0;
  assign disp      = stb.selDisp ? bits[0       +: DISP_W] : '0;

  always_comb begin
    // R7
    disp_alone_chk: assert (disp == '0 || (regB == '0 && regC == '0 && crField == '0))
      else $error("displacement routed beside register fields");
    // R9
    mask_no_target_chk: assert (fieldMask == '0 || (regT == '0 && regA == '0))
      else $error("field mask routed beside T/A");
  end
endmodule

// File: rtl/fp_insn_decoder.sv
module fp_insn_decoder
  import fpdec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic [OP_W-1:0]   op,
  output logic [FORM_W-1:0] form,
  output logic              isDouble,
  output logic              record,
  output logic              illegal,
  output logic [REG_W-1:0]  regT,
  output logic [REG_W-1:0]  regA,
  output logic [REG_W-1:0]  regB,
  output logic [REG_W-1:0]  regC,
  output logic [CRF_W-1:0]  crField,
  output logic [CRF_W-1:0]  crSrc,
  output logic [IMM_W-1:0]  imm4,
  output logic [MASK_W-1:0] fieldMask,
  output logic [REG_W-1:0]  bitNum,
  output logic [DISP_W-1:0] disp
);
  fpOp_e        ctlOp;
  fpForm_e      ctlForm;
  fieldStrobe_t stb;

  fpdec_ctrl i_ctrl (
    .prim     (insn[INSN_W-1 -: PRIM_W]),
    .xo       (insn[XO_W:1]),
    .rc       (insn[0]),
    .op       (ctlOp),
    .form     (ctlForm),
    .isDouble (isDouble),
    .record   (record),
    .illegal  (illegal),
    .stb      (stb)
  );

  fpdec_fields i_fields (
    .bits      (insn[LOW_W-1:0]),
    .stb       (stb),
    .regT      (regT),
    .regA      (regA),
    .regB      (regB),
    .regC      (regC),
    .crField   (crField),
    .crSrc     (crSrc),
    .imm4      (imm4),
    .fieldMask (fieldMask),
    .bitNum    (bitNum),
    .disp      (disp)
  );

  assign op   = ctlOp;
  assign form = ctlForm;
endmodule

// File: tb/test_fp_insn_decoder.sv
module test_fp_insn_decoder;
  import fpdec_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] insn = '0;
  logic [5:0]  op;
  logic [3:0]  form;
  logic        isDouble, record, illegal;
  logic [4:0]  regT, regA, regB, regC, bitNum;
  logic [2:0]  crField, crSrc;
  logic [3:0]  imm4;
  logic [7:0]  fieldMask;
  logic [15:0] disp;

  fp_insn_decoder i_fp_insn_decoder (
    .insn, .op, .form, .isDouble, .record, .illegal,
    .regT, .regA, .regB, .regC, .crField, .crSrc,
    .imm4, .fieldMask, .bitNum, .disp
  );

  typedef struct packed {
    logic [5:0] op; logic [3:0] form; logic dbl; logic rec; logic ill;
    logic [4:0] t; logic [4:0] a; logic [4:0] b; logic [4:0] c;
    logic [2:0] crf; logic [2:0] crs; logic [3:0] imm; logic [7:0] mask;
    logic [4:0] bitn; logic [15:0] disp;
  } res_t;

  res_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  function automatic res_t model(input logic [31:0] w, input logic [5:0] eop,
                                 input logic [3:0] ef, input logic ed);
    res_t r = '0;
    if (ef == 4'd0) begin
      r.op = OP_NONE; r.ill = 1'b1;
      return r;
    end
    r.op = eop; r.form = ef; r.dbl = ed; r.rec = w[0];
    case (ef)
      4'd4, 4'd5:        begin r.t = w[25:21]; r.a = w[20:16]; r.disp = w[15:0]; end
      4'd1, 4'd8, 4'd9:  begin r.t = w[25:21]; r.a = w[20:16]; r.b = w[15:11]; end
      4'd2:              begin r.t = w[25:21]; r.a = w[20:16]; r.c = w[10:6]; end
      4'd3:              begin r.t = w[25:21]; r.a = w[20:16]; r.b = w[15:11]; r.c = w[10:6]; end
      4'd7:              begin r.t = w[25:21]; r.b = w[15:11]; end
      4'd6:              r.t = w[25:21];
      4'd10:             begin r.crf = w[25:23]; r.a = w[20:16]; r.b = w[15:11]; end
      4'd11:             begin r.crf = w[25:23]; r.crs = w[20:18]; end
      4'd12:             r.bitn = w[25:21];
      4'd13:             begin r.crf = w[25:23]; r.imm = w[15:12]; end
      4'd14:             begin r.mask = w[24:17]; r.b = w[15:11]; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] mkA(input logic [5:0] p, input logic [4:0] t, input logic [4:0] a,
                                      input logic [4:0] b, input logic [4:0] c, input logic [4:0] x,
                                      input logic rc);
    return {p, t, a, b, c, x, rc};
  endfunction

  function automatic logic [31:0] mkX(input logic [5:0] p, input logic [4:0] t, input logic [4:0] a,
                                      input logic [4:0] b, input logic [9:0] x, input logic rc);
    return {p, t, a, b, x, rc};
  endfunction

  task automatic send(input logic [31:0] w, input logic [5:0] eop, input logic [3:0] ef,
                      input logic ed, input string tag);
    @(negedge clk);
    insn = w;
    expQ.push_back(model(w, eop, ef, ed));
    tagQ.push_back(tag);
  endtask

  // Monitor: pops one expected item per cycle, results settled since the last negedge
  always @(posedge clk) begin
    if (!rst && expQ.size() > 0) begin
      res_t  e;
      res_t  act;
      string tg;
      e  = expQ.pop_front();
      tg = tagQ.pop_front();
      act = '{op, form, isDouble, record, illegal, regT, regA, regB, regC,
              crField, crSrc, imm4, fieldMask, bitNum, disp};
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: insn=%h actual=%h expected=%h", tg, insn, act, e);
      end
    end
  end

  fpOp_e o59[11] = '{OP_DIV, OP_SUB, OP_ADD, OP_SQRT, OP_RECIP_EST, OP_MUL, OP_RSQRT_EST,
                     OP_MSUB, OP_MADD, OP_NMSUB, OP_NMADD};
  int    x59[11] = '{18, 20, 21, 22, 24, 25, 26, 28, 29, 30, 31};
  int    f59[11] = '{1, 1, 1, 7, 7, 2, 7, 3, 3, 3, 3};
  fpOp_e o63[15] = '{OP_CMP_U, OP_RND_SGL, OP_CVT_W, OP_CVT_WZ, OP_CMP_O, OP_STAT_SET, OP_NEG,
                     OP_STAT_TOCR, OP_STAT_CLR, OP_MOVE, OP_STAT_IMM, OP_NABS, OP_ABS,
                     OP_STAT_RD, OP_STAT_WRF};
  int    x63[15] = '{0, 12, 14, 15, 32, 38, 40, 64, 70, 72, 134, 136, 264, 583, 711};
  int    f63[15] = '{10, 7, 7, 7, 10, 12, 7, 11, 12, 7, 13, 7, 7, 6, 14};

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R11 reset state: all-zero word is an unknown primary opcode
    send(32'h0, OP_NONE, 4'd0, 1'b0, "R11 zero word");

    for (int i = 0; i < 8; i++) begin
      logic [5:0] eop;
      eop = i[2] ? (i[1] ? OP_ST_D : OP_ST_S) : (i[1] ? OP_LD_D : OP_LD_S);
      send({6'(48 + i), 5'(i + 3), 5'(29 - i), 16'h8001 + 16'(i * 4369)},
           eop, i[0] ? 4'd5 : 4'd4, i[1], "R1 displacement memory form");
      send(mkX(6'd31, 5'(i + 9), 5'(i + 1), 5'(31 - i), 10'(535 + 32 * i), 1'b0),
           eop, i[0] ? 4'd9 : 4'd8, i[1], "R2 indexed memory form");
    end
    send(mkX(6'd31, 5'd7, 5'd12, 5'd19, 10'd983, 1'b0), OP_ST_IW, 4'd8, 1'b0, "R3 integer word store");

    for (int i = 0; i < 11; i++) begin
      send(mkA(6'd59, 5'(i + 2), 5'(20 - i), 5'(i * 2), 5'(31 - i), 5'(x59[i]), i[0]),
           o59[i], 4'(f59[i]), 1'b0, "R4 R7 single arithmetic");
      send(mkA(6'd63, 5'(i + 11), 5'(i + 5), 5'(30 - i), 5'(i + 17), 5'(x59[i]), ~i[0]),
           o59[i], 4'(f59[i]), 1'b1, "R5 R7 double arithmetic");
    end
    send(mkA(6'd63, 5'd1, 5'd2, 5'd3, 5'd4, 5'd23, 1'b1), OP_SEL, 4'd3, 1'b1, "R5 select");
    send(mkA(6'd59, 5'd1, 5'd2, 5'd3, 5'd4, 5'd23, 1'b0), OP_NONE, 4'd0, 1'b0, "R4 select absent in single");
    send(mkA(6'd59, 5'd6, 5'd6, 5'd6, 5'd6, 5'd19, 1'b1), OP_NONE, 4'd0, 1'b0, "R4 R11 unmatched short");
    send(mkA(6'd63, 5'd6, 5'd6, 5'd6, 5'd6, 5'd17, 1'b1), OP_NONE, 4'd0, 1'b0, "R5 R11 unmatched short");

    for (int i = 0; i < 15; i++) begin
      send(mkX(6'd63, 5'(29 - i), 5'(i * 2 + 1), 5'(i + 14), 10'(x63[i]), i[0]),
           o63[i], 4'(f63[i]), 1'b1, "R6 R8 R9 extended table");
      send(mkX(6'd63, 5'(i + 16), 5'(27 - i), 5'(3 * i), 10'(x63[i]), ~i[0]),
           o63[i], 4'(f63[i]), 1'b1, "R6 R8 R9 extended table alt fields");
    end
    send(32'hFFFF_FFFF & mkX(6'd63, 5'd31, 5'd31, 5'd31, 10'd711, 1'b1), OP_STAT_WRF, 4'd14, 1'b1, "R9 full mask");
    send(mkX(6'd63, 5'd9, 5'd9, 5'd9, 10'd1, 1'b1), OP_NONE, 4'd0, 1'b0, "R6 R11 unmatched extended");
    send(mkX(6'd31, 5'd9, 5'd9, 5'd9, 10'd536, 1'b1), OP_NONE, 4'd0, 1'b0, "R2 R11 unmatched indexed");
    send({6'd1, 26'h3FF_FFFF}, OP_NONE, 4'd0, 1'b0, "R11 R10 primary 1 with bit0 set");
    send({6'd47, 26'h155_5555}, OP_NONE, 4'd0, 1'b0, "R11 primary 47");
    send({6'd56, 26'h2AA_AAAB}, OP_NONE, 4'd0, 1'b0, "R11 primary 56");
    send(mkA(6'd63, 5'd4, 5'd5, 5'd6, 5'd7, 5'd21, 1'b1), OP_ADD, 4'd1, 1'b1, "R10 record set");
    send({6'd50, 5'd2, 5'd3, 16'h0001}, OP_LD_D, 4'd4, 1'b1, "R10 R1 bit0 in displacement");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule